// File: doc/BRIEF.md
# Two-List Second-Chance Page Manager

This block tracks which page tags are resident, keeping them in two chained lists. The first, the active list, holds pages the program may touch directly and is kept in arrival order: new arrivals enter at the front, and its oldest entry leaves from the tail. The second, the second-chance list, holds pages that were pushed out of the active list. Those pages are marked inaccessible, and the list is kept in least-recently-used order. A page pushed out of the active list enters this list at its front. When this list overflows, its tail is dropped to backing store.

Each cycle one request may arrive, carrying a page tag. The block searches both lists at once and reports one of three results. A hit means the tag is in the active list. A rescue means the tag is found in the second-chance list and is moved back to the front of the active list without a disk access. A page-in means the tag is in neither list and is inserted at the front of the active list. When a page-in forces the least-recently-used page out of a full second-chance list, the block also reports that page's tag as the victim to write back. If the second-chance list depth is set to zero, the active tail is evicted directly and the block behaves as plain FIFO replacement.

Top module: `twolist_pager`

## Requirements
- R1: A request whose tag is in the active list gives hit=1 and leaves the order of both lists unchanged.
- R2: A request whose tag is in the second-chance list gives rescue=1. The entry is removed from that list and inserted at the front of the active list. The next request for that tag is a hit.
- R3: A request whose tag is in neither list gives page_in=1 and inserts the tag at the front of the active list. The next request for that tag is a hit.
- R4: When an insertion overflows a full active list, its tail entry moves to the front of the second-chance list. A later request for that tag gives rescue=1.
- R5: When a demotion overflows a full second-chance list, its tail entry (the least recently used) is dropped. In the same result cycle, evict_valid=1 and evict_tag carries the dropped tag. A rescue never evicts.
- R6: Starting from empty, the first NUM_ACT+NUM_SC page-ins of distinct tags give evict_valid=0.
- R7: Each request produces exactly one of hit, rescue and page_in. A cycle with req_valid=0 produces none of these and no eviction.
- R8: All results are registered. They appear in the cycle after the request and not in the request cycle itself.
- R9: With NUM_SC=0, a page-in to a full active list evicts the active tail directly. This is FIFO replacement.
- R10: A tag is held in at most one entry across both lists.
- R11: After reset both lists are empty and all outputs are 0, so the first request for any tag is a page-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_tag | input | TAG_W | Page tag of the request |
| hit | output | 1 | Previous request found the tag in the active list |
| rescue | output | 1 | Previous request recovered the tag from the second-chance list |
| page_in | output | 1 | Previous request found the tag in neither list |
| evict_valid | output | 1 | Previous request dropped a page to backing store |
| evict_tag | output | TAG_W | Tag of the dropped page |

## Verification
The bench fills both lists from empty and then forces overflow. A design that evicts while filling, or that evicts from the front of the second-chance list rather than its tail, reports the wrong victim. Rescues are taken both from the middle and from the tail of the second-chance list while the active list is full. A design that loses the demoted active tail, or that fails to close the gap left by the rescued entry, shows a wrong eviction order a few requests later. A hit is placed between overflows, so a design that reorders on a hit moves that page out of turn. A separate instance with no second-chance list checks that the design falls back to plain FIFO eviction.

// File: rtl/tlpm_pkg.sv
package tlpm_pkg;

  // Kind of result produced for one request
  typedef enum logic [1:0] {
    RES_NONE   = 2'd0,
    RES_HIT    = 2'd1,
    RES_RESCUE = 2'd2,
    RES_PAGEIN = 2'd3
  } res_e;

endpackage

// File: rtl/tlpm_list.sv
// Ordered tag list: index 0 is the front. Supports insert-at-front,
// remove-at-index, or both in one cycle; valid entries stay packed at the front.
module tlpm_list #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  output logic [IW-1:0]    look_idx,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic             rm_en,
  input  logic [IW-1:0]    rm_idx,
  output logic             tail_valid,
  output logic [TAG_W-1:0] tail_tag
);

  logic             vld_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic             vld_d [DEPTH];
  logic [TAG_W-1:0] tag_d [DEPTH];
  logic [DEPTH-1:0] match;
  logic             upd_en;

  // Associative search
  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign match[i] = vld_q[i] && (tag_q[i] == look_tag);
  end

  assign look_hit = |match;

  always_comb begin
    look_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) look_idx = IW'(i);
    end
  end

  assign tail_valid = vld_q[DEPTH-1];
  assign tail_tag   = tag_q[DEPTH-1];
  assign upd_en     = ins_en | rm_en;

  // Next-state per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic shift_in;
    logic shift_out;
    assign shift_in  = ins_en && (!rm_en || (i <= int'(rm_idx)));
    assign shift_out = !ins_en && rm_en && (i >= int'(rm_idx));

    if (i == 0) begin : g_front
      always_comb begin
        vld_d[i] = vld_q[i];
        tag_d[i] = tag_q[i];
        if (shift_in) begin
          vld_d[i] = 1'b1;
          tag_d[i] = ins_tag;
        end else if (shift_out) begin
          if (DEPTH > 1) begin
            vld_d[i] = vld_q[(DEPTH > 1) ? 1 : 0];
            tag_d[i] = tag_q[(DEPTH > 1) ? 1 : 0];
          end else begin
            vld_d[i] = 1'b0;
          end
        end
      end
    end else if (i == DEPTH-1) begin : g_back
      always_comb begin
        vld_d[i] = vld_q[i];
        tag_d[i] = tag_q[i];
        if (shift_in) begin
          vld_d[i] = vld_q[i-1];
          tag_d[i] = tag_q[i-1];
        end else if (shift_out) begin
          vld_d[i] = 1'b0;
        end
      end
    end else begin : g_mid
      always_comb begin
        vld_d[i] = vld_q[i];
        tag_d[i] = tag_q[i];
        if (shift_in) begin
          vld_d[i] = vld_q[i-1];
          tag_d[i] = tag_q[i-1];
        end else if (shift_out) begin
          vld_d[i] = vld_q[i+1];
          tag_d[i] = tag_q[i+1];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
      end else if (upd_en) begin
        vld_q[i] <= vld_d[i];
        tag_q[i] <= tag_d[i];
      end
    end
  end

endmodule

// File: rtl/tlpm_ctrl.sv
// Decides the list operations for one request and registers the results.
module tlpm_ctrl
  import tlpm_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter bit HAS_SC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             act_match,
  input  logic             sc_match,
  input  logic             act_full,
  input  logic [TAG_W-1:0] act_tail_tag,
  input  logic             sc_full,
  input  logic [TAG_W-1:0] sc_tail_tag,
  output logic             act_ins_en,
  output logic             sc_ins_en,
  output logic             sc_rm_en,
  output logic             hit,
  output logic             rescue,
  output logic             page_in,
  output logic             evict_valid,
  output logic [TAG_W-1:0] evict_tag
);

  res_e             res_d, res_q;
  logic             ev_d, ev_q;
  logic [TAG_W-1:0] ev_tag_d, ev_tag_q;
  logic             demote;

  always_comb begin
    res_d = RES_NONE;
    if (req_valid) begin
      if (act_match)     res_d = RES_HIT;
      else if (sc_match) res_d = RES_RESCUE;
      else               res_d = RES_PAGEIN;
    end
  end

  assign act_ins_en = (res_d == RES_RESCUE) || (res_d == RES_PAGEIN);
  assign demote     = HAS_SC && act_ins_en && act_full;
  assign sc_ins_en  = demote;
  assign sc_rm_en   = (res_d == RES_RESCUE);

  always_comb begin
    ev_d     = 1'b0;
    ev_tag_d = ev_tag_q;
    if (res_d == RES_PAGEIN && act_full) begin
      if (HAS_SC) begin
        ev_d     = sc_full;
        ev_tag_d = sc_full ? sc_tail_tag : ev_tag_q;
      end else begin
        ev_d     = 1'b1;
        ev_tag_d = act_tail_tag;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= RES_NONE;
      ev_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      ev_q  <= ev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_tag_q <= '0;
    end else if (ev_d) begin
      ev_tag_q <= ev_tag_d;
    end
  end

  assign hit         = (res_q == RES_HIT);
  assign rescue      = (res_q == RES_RESCUE);
  assign page_in     = (res_q == RES_PAGEIN);
  assign evict_valid = ev_q;
  assign evict_tag   = ev_tag_q;

endmodule

// File: rtl/twolist_pager.sv
module twolist_pager #(
  parameter int NUM_ACT = 4,
  parameter int NUM_SC  = 4,
  parameter int TAG_W   = 8,
  localparam int SC_D   = (NUM_SC > 0) ? NUM_SC : 1,
  localparam int SC_IW  = (SC_D > 1) ? $clog2(SC_D) : 1,
  localparam int ACT_IW = (NUM_ACT > 1) ? $clog2(NUM_ACT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit,
  output logic             rescue,
  output logic             page_in,
  output logic             evict_valid,
  output logic [TAG_W-1:0] evict_tag
);

  logic              act_match;
  logic [ACT_IW-1:0] act_idx;
  logic              act_full;
  logic [TAG_W-1:0]  act_tail_tag;
  logic              act_ins_en;
  logic              sc_match;
  logic              sc_full;
  logic [TAG_W-1:0]  sc_tail_tag;
  logic              sc_ins_en;
  logic              sc_rm_en;
  logic              victim_full;

  tlpm_list #(.DEPTH(NUM_ACT), .TAG_W(TAG_W)) u_act (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_tag   (req_tag),
    .look_hit   (act_match),
    .look_idx   (act_idx),
    .ins_en     (act_ins_en),
    .ins_tag    (req_tag),
    .rm_en      (1'b0),
    .rm_idx     ('0),
    .tail_valid (act_full),
    .tail_tag   (act_tail_tag)
  );

  if (NUM_SC > 0) begin : g_sc
    logic [SC_IW-1:0] sc_idx;
    tlpm_list #(.DEPTH(SC_D), .TAG_W(TAG_W)) u_sc (
      .clk        (clk),
      .rst_n      (rst_n),
      .look_tag   (req_tag),
      .look_hit   (sc_match),
      .look_idx   (sc_idx),
      .ins_en     (sc_ins_en),
      .ins_tag    (act_tail_tag),
      .rm_en      (sc_rm_en),
      .rm_idx     (sc_idx),
      .tail_valid (sc_full),
      .tail_tag   (sc_tail_tag)
    );
    assign victim_full = sc_full;
  end else begin : g_no_sc
    assign sc_match    = 1'b0;
    assign sc_full     = 1'b0;
    assign sc_tail_tag = '0;
    assign victim_full = act_full;
  end

  tlpm_ctrl #(.TAG_W(TAG_W), .HAS_SC(NUM_SC > 0)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .act_match    (act_match),
    .sc_match     (sc_match),
    .act_full     (act_full),
    .act_tail_tag (act_tail_tag),
    .sc_full      (sc_full),
    .sc_tail_tag  (sc_tail_tag),
    .act_ins_en   (act_ins_en),
    .sc_ins_en    (sc_ins_en),
    .sc_rm_en     (sc_rm_en),
    .hit          (hit),
    .rescue       (rescue),
    .page_in      (page_in),
    .evict_valid  (evict_valid),
    .evict_tag    (evict_tag)
  );

endmodule

// File: rtl/tlpm_checker.sv
module tlpm_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic hit,
  input logic rescue,
  input logic page_in,
  input logic evict_valid,
  input logic act_match,
  input logic sc_match,
  input logic victim_full
);

  assert_one_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, rescue, page_in}));

  assert_request_answered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (hit || rescue || page_in));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(hit || rescue || page_in || evict_valid));

  assert_evict_on_pagein_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> page_in);

  assert_no_evict_unfilled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !victim_full) |=> !evict_valid);

  assert_single_home_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !(act_match && sc_match));

endmodule

bind twolist_pager tlpm_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .hit         (hit),
  .rescue      (rescue),
  .page_in     (page_in),
  .evict_valid (evict_valid),
  .act_match   (act_match),
  .sc_match    (sc_match),
  .victim_full (victim_full)
);

// File: tb/twolist_pager_bench.sv
`timescale 1ns/1ps
module twolist_pager_bench;

  localparam int R_NONE = 0, R_HIT = 1, R_RESC = 2, R_PIN = 3;

  logic       clk;
  logic       rst_n;
  logic       req_valid, f_req_valid;
  logic [7:0] req_tag, f_req_tag;
  logic       hit, rescue, page_in, evict_valid;
  logic [7:0] evict_tag;
  logic       f_hit, f_rescue, f_page_in, f_evict_valid;
  logic [7:0] f_evict_tag;
  int         nvec, nfail;

  twolist_pager #(.NUM_ACT(4), .NUM_SC(4), .TAG_W(8)) u_twolist_pager (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .hit(hit), .rescue(rescue), .page_in(page_in),
    .evict_valid(evict_valid), .evict_tag(evict_tag));

  twolist_pager #(.NUM_ACT(4), .NUM_SC(0), .TAG_W(8)) u_twolist_pager_fifo (
    .clk(clk), .rst_n(rst_n), .req_valid(f_req_valid), .req_tag(f_req_tag),
    .hit(f_hit), .rescue(f_rescue), .page_in(f_page_in),
    .evict_valid(f_evict_valid), .evict_tag(f_evict_tag));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int code(logic h, logic r, logic p);
    return {29'd0, p, r, h} == 3'b001 ? R_HIT :
           {29'd0, p, r, h} == 3'b010 ? R_RESC :
           {29'd0, p, r, h} == 3'b100 ? R_PIN :
           {29'd0, p, r, h} == 3'b000 ? R_NONE : 7;
  endfunction

  task automatic check(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One request with an idle cycle after; result checked one cycle later (R8).
  task automatic access(bit fifo, logic [7:0] tag, int exp_res, bit exp_ev,
                        logic [7:0] exp_tag, string req);
    @(negedge clk);
    if (fifo) begin f_req_valid = 1'b1; f_req_tag = tag; end
    else      begin req_valid   = 1'b1; req_tag   = tag; end
    #1;
    check("R8 no result in request cycle",
          fifo ? code(f_hit, f_rescue, f_page_in) : code(hit, rescue, page_in), R_NONE);
    @(negedge clk);
    f_req_valid = 1'b0;
    req_valid   = 1'b0;
    check({req, " result"},
          fifo ? code(f_hit, f_rescue, f_page_in) : code(hit, rescue, page_in), exp_res);
    check({req, " evict_valid"}, int'(fifo ? f_evict_valid : evict_valid), int'(exp_ev));
    if (exp_ev)
      check({req, " evict_tag"}, int'(fifo ? f_evict_tag : evict_tag), int'(exp_tag));
  endtask

  task automatic t_reset;
    check("R11 reset result", code(hit, rescue, page_in), R_NONE);
    check("R11 reset evict", int'(evict_valid), 0);
    access(0, 8'd1, R_PIN, 0, 8'd0, "R11 first access after reset");
  endtask

  task automatic t_fill;
    for (int t = 2; t <= 8; t++) access(0, 8'(t), R_PIN, 0, 8'd0, "R6 fill");
    // active [8,7,6,5], second-chance [4,3,2,1]
  endtask

  task automatic t_overflow;
    access(0, 8'd9, R_PIN, 1, 8'd1, "R5 evict LRU tail");     // sc [5,4,3,2]
    access(0, 8'd7, R_HIT, 0, 8'd0, "R1 active hit");
    access(0, 8'd3, R_RESC, 0, 8'd0, "R2 rescue middle");     // act [3,9,8,7] sc [6,5,4,2]
    access(0, 8'd3, R_HIT, 0, 8'd0, "R2 rescued now hit");
    access(0, 8'd10, R_PIN, 1, 8'd2, "R10 gap closed after rescue"); // sc [7,6,5,4]
    access(0, 8'd11, R_PIN, 1, 8'd4, "R1 hit did not reorder");     // sc [8,7,6,5]
    access(0, 8'd1, R_PIN, 1, 8'd5, "R3 evicted tag paged in");     // act [1,11,10,3] sc [9,8,7,6]
    access(0, 8'd1, R_HIT, 0, 8'd0, "R3 paged-in now hit");
    access(0, 8'd9, R_RESC, 0, 8'd0, "R4 demoted tag rescued");     // act [9,1,11,10] sc [3,8,7,6]
    access(0, 8'd6, R_RESC, 0, 8'd0, "R2 rescue tail");             // act [6,9,1,11] sc [10,3,8,7]
    access(0, 8'd12, R_PIN, 1, 8'd7, "R5 LRU after rescues");       // sc [11,10,3,8]
    access(0, 8'd10, R_RESC, 0, 8'd0, "R4 demote order");
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    check("R7 idle result", code(hit, rescue, page_in), R_NONE);
    check("R7 idle evict", int'(evict_valid), 0);
  endtask

  task automatic t_fifo;
    for (int t = 1; t <= 4; t++) access(1, 8'(t), R_PIN, 0, 8'd0, "R9 fifo fill");
    access(1, 8'd5, R_PIN, 1, 8'd1, "R9 fifo evict oldest");
    access(1, 8'd1, R_PIN, 1, 8'd2, "R9 fifo evict next");
    access(1, 8'd3, R_HIT, 0, 8'd0, "R9 fifo hit");
    access(1, 8'd6, R_PIN, 1, 8'd3, "R9 hit keeps fifo order");
  endtask

  initial begin
    nvec = 0; nfail = 0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_tag = '0;
    f_req_valid = 1'b0; f_req_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_overflow();
    t_idle();
    t_fifo();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule